// File: doc/BRIEF.md
# Raster Timing Generator with Separate Data-Valid Window

This block produces the horizontal and vertical timing of a display raster from a small set of static parameters: sync pulse widths, back and front porches, active width and height, and a horizontal skew that shifts the vertical window by a number of clocks. Alongside the usual sync pulses and display-enable window, it drives a data-valid strobe. The data-valid strobe can be narrower than the active line. Its width follows the payload actually carried per line, which is smaller when the stream is compressed or when two pixels travel in each clock.

The vertical window is defined on a linear clock index within the frame, which is line number times horizontal period plus column. This lets the skew and the edge-aligned mode place the first and last active clocks in the middle of a line. In edge-aligned mode the vertical window starts at the first active column of the first active line and ends at the last active column of the last active line. The configuration is captured into shadow registers while the generator is disabled and again at each frame boundary, so writes made mid-frame take effect cleanly on the next frame.

Top module: `raster_timing_gen`

## Requirements
- R1: With `en` high the column counter `h_cnt` steps by one each clock and returns to 0 after hperiod−1, where hperiod = hsync width + h back porch + h active + h front porch. The line counter `v_cnt` advances only on that wrap and returns to 0 after vperiod−1, with vperiod built in the same way from the vertical parameters.
- R2: `hsync` is high for columns 0 to hsync width−1 of every line. `vsync` is high for lines 0 to vsync width−1 of every frame.
- R3: The horizontal active region covers columns hstart = hsync width + h back porch through hperiod − h front porch − 1. `de` is high only inside it and only inside the vertical window.
- R4: Let lin = v_cnt×hperiod + h_cnt. The vertical window covers lin from (vsync width + v back porch)×hperiod + skew through (vperiod − v front porch)×hperiod + skew − 1.
- R5: With `cfg_dp_mode` high, the vertical window start moves later by hsync width + h back porch, and its end moves earlier by h front porch.
- R6: With `cfg_comp_en` high, the data width is ceil(`cfg_comp_bytes`/3). When `cfg_wide_en` is also high, that value is shifted right by one.
- R7: With `cfg_comp_en` low, the data width is h active/2 (shift right by one) when `cfg_wide_en` is high and `cfg_dp_mode` is low. Otherwise the data width is h active.
- R8: Except in the case of R9, `dv` is high inside the vertical window for columns hstart through hstart + data width − 1.
- R9: With `cfg_comp_en` high and `cfg_wide_en` low, `dv` equals `de` on every clock.
- R10: While `en` is low, all four strobes are low. After the first clock edge with `en` low, both counters are 0. The first enabled clock shows position (0,0).
- R11: The configuration is captured on every clock edge where `en` is low, and on the edge that ends the last clock of a frame. A change at any other time does not alter the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the raster at its origin |
| cfg_hsync_w | input | HW | Hsync pulse width in clocks |
| cfg_hbp | input | HW | Horizontal back porch |
| cfg_hact | input | HW | Active width in clocks |
| cfg_hfp | input | HW | Horizontal front porch |
| cfg_vsync_w | input | VW | Vsync pulse width in lines |
| cfg_vbp | input | VW | Vertical back porch |
| cfg_vact | input | VW | Active height in lines |
| cfg_vfp | input | VW | Vertical front porch |
| cfg_hskew | input | HW | Skew added to both vertical window bounds |
| cfg_comp_en | input | 1 | Compressed stream |
| cfg_comp_bytes | input | BW | Compressed bytes per line |
| cfg_wide_en | input | 1 | Two pixels per clock |
| cfg_dp_mode | input | 1 | Edge-aligned vertical window mode |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| dv | output | 1 | Data valid |
| h_cnt | output | HW | Column counter |
| v_cnt | output | VW | Line counter |

## Verification
On every cycle, the assertions check the counter stepping, that both windows stay clear of the horizontal sync pulse, that display enable never overlaps vsync, and that all strobes are low while disabled. The exact window edges are checked only by the bench scenarios. These include the data width for each combination of compression, wide-bus and edge-aligned flags, odd byte counts that exercise the round-up and the halving, skew that cuts into the first active line, and a configuration change made in mid-frame. The bench compares them clock by clock against a behavioural model.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  typedef enum logic [1:0] {
    DW_FULL      = 2'd0,
    DW_HALF      = 2'd1,
    DW_COMP      = 2'd2,
    DW_COMP_HALF = 2'd3
  } dw_sel_e;

  function automatic dw_sel_e dw_select(input logic comp, input logic wide, input logic dp);
    if (comp)             return wide ? DW_COMP_HALF : DW_COMP;
    else if (wide && !dp) return DW_HALF;
    else                  return DW_FULL;
  endfunction

endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] hsync_w,
  input  logic [HW-1:0] hbp,
  input  logic [HW-1:0] hact,
  input  logic [HW-1:0] hfp,
  input  logic [VW-1:0] vsync_w,
  input  logic [VW-1:0] vbp,
  input  logic [VW-1:0] vact,
  input  logic [VW-1:0] vfp,
  input  logic [HW-1:0] hskew,
  input  logic          comp_en,
  input  logic [BW-1:0] comp_bytes,
  input  logic          wide_en,
  input  logic          dp_mode,
  output logic [HW-1:0]    s_hp,
  output logic [VW-1:0]    s_vp,
  output logic [HW-1:0]    s_hsw,
  output logic [VW-1:0]    s_vsw,
  output logic [HW-1:0]    s_hstart,
  output logic [HW-1:0]    s_hend,
  output logic [HW-1:0]    s_dend,
  output logic [HW+VW-1:0] s_vstart,
  output logic [HW+VW-1:0] s_vend,
  output logic             s_follow
);
  import rtg_pkg::*;

  localparam int LW = HW + VW;
  localparam int CW = BW + 1;
  localparam logic [CW-1:0] ROUND2 = CW'(2);
  localparam logic [CW-1:0] DIV3   = CW'(3);

  logic [HW-1:0] hp_n, hstart_n, hend_n, dw_n, dend_n;
  logic [VW-1:0] vp_n, vlead_n, vlast_n;
  logic [LW-1:0] vstart_n, vend_n;
  logic [CW-1:0] cdiv_n;
  dw_sel_e       sel_n;

  always_comb begin
    hp_n     = hsync_w + hbp + hact + hfp;
    vp_n     = vsync_w + vbp + vact + vfp;
    hstart_n = hsync_w + hbp;
    hend_n   = hp_n - hfp - HW'(1);
    vlead_n  = vsync_w + vbp;
    vlast_n  = vp_n - vfp;
    vstart_n = LW'(vlead_n) * LW'(hp_n) + LW'(hskew);
    vend_n   = LW'(vlast_n) * LW'(hp_n) + LW'(hskew) - LW'(1);
    if (dp_mode) begin
      vstart_n = vstart_n + LW'(hstart_n);
      vend_n   = vend_n - LW'(hfp);
    end
    cdiv_n = (CW'(comp_bytes) + ROUND2) / DIV3;
    sel_n  = dw_select(comp_en, wide_en, dp_mode);
    case (sel_n)
      DW_COMP:      dw_n = HW'(cdiv_n);
      DW_COMP_HALF: dw_n = HW'(cdiv_n >> 1);
      DW_HALF:      dw_n = hact >> 1;
      default:      dw_n = hact;
    endcase
    dend_n = hstart_n + dw_n - HW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_hp     <= '0;
      s_vp     <= '0;
      s_hsw    <= '0;
      s_vsw    <= '0;
      s_hstart <= '0;
      s_hend   <= '0;
      s_dend   <= '0;
      s_vstart <= '0;
      s_vend   <= '0;
      s_follow <= 1'b0;
    end else if (load) begin
      s_hp     <= hp_n;
      s_vp     <= vp_n;
      s_hsw    <= hsync_w;
      s_vsw    <= vsync_w;
      s_hstart <= hstart_n;
      s_hend   <= hend_n;
      s_dend   <= dend_n;
      s_vstart <= vstart_n;
      s_vend   <= vend_n;
      s_follow <= comp_en && !wide_en;
    end
  end

endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [HW-1:0]    hp,
  input  logic [VW-1:0]    vp,
  output logic [HW-1:0]    h,
  output logic [VW-1:0]    v,
  output logic [HW+VW-1:0] lin,
  output logic             frame_end
);
  localparam int LW = HW + VW;

  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;
  logic [LW-1:0] lin_n;
  logic          line_end;

  always_comb begin
    line_end  = (h == hp - HW'(1));
    frame_end = en && line_end && (v == vp - VW'(1));
    h_n   = h + HW'(1);
    v_n   = v;
    lin_n = lin + LW'(1);
    if (!en || frame_end) begin
      h_n   = '0;
      v_n   = '0;
      lin_n = '0;
    end else if (line_end) begin
      h_n = '0;
      v_n = v + VW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h   <= '0;
      v   <= '0;
      lin <= '0;
    end else begin
      h   <= h_n;
      v   <= v_n;
      lin <= lin_n;
    end
  end

endmodule

// File: rtl/rtg_decode.sv
module rtg_decode #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic             en,
  input  logic [HW-1:0]    h,
  input  logic [VW-1:0]    v,
  input  logic [HW+VW-1:0] lin,
  input  logic [HW-1:0]    s_hsw,
  input  logic [VW-1:0]    s_vsw,
  input  logic [HW-1:0]    s_hstart,
  input  logic [HW-1:0]    s_hend,
  input  logic [HW-1:0]    s_dend,
  input  logic [HW+VW-1:0] s_vstart,
  input  logic [HW+VW-1:0] s_vend,
  input  logic             s_follow,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             dv
);
  logic in_v, in_h, in_d;

  always_comb begin
    in_v  = (lin >= s_vstart) && (lin <= s_vend);
    in_h  = (h >= s_hstart) && (h <= s_hend);
    in_d  = s_follow ? in_h : ((h >= s_hstart) && (h <= s_dend));
    hsync = en && (h < s_hsw);
    vsync = en && (v < s_vsw);
    de    = en && in_v && in_h;
    dv    = en && in_v && in_d;
  end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [HW-1:0] cfg_hsync_w,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [VW-1:0] cfg_vsync_w,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [HW-1:0] cfg_hskew,
  input  logic          cfg_comp_en,
  input  logic [BW-1:0] cfg_comp_bytes,
  input  logic          cfg_wide_en,
  input  logic          cfg_dp_mode,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          dv,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt
);
  localparam int LW = HW + VW;

  logic [HW-1:0] s_hp, s_hsw, s_hstart, s_hend, s_dend;
  logic [VW-1:0] s_vp, s_vsw;
  logic [LW-1:0] s_vstart, s_vend, lin;
  logic          s_follow, frame_end, load;

  assign load = !en || frame_end;

  rtg_shadow #(.HW(HW), .VW(VW), .BW(BW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .hsync_w(cfg_hsync_w), .hbp(cfg_hbp), .hact(cfg_hact), .hfp(cfg_hfp),
    .vsync_w(cfg_vsync_w), .vbp(cfg_vbp), .vact(cfg_vact), .vfp(cfg_vfp),
    .hskew(cfg_hskew), .comp_en(cfg_comp_en), .comp_bytes(cfg_comp_bytes),
    .wide_en(cfg_wide_en), .dp_mode(cfg_dp_mode),
    .s_hp(s_hp), .s_vp(s_vp), .s_hsw(s_hsw), .s_vsw(s_vsw),
    .s_hstart(s_hstart), .s_hend(s_hend), .s_dend(s_dend),
    .s_vstart(s_vstart), .s_vend(s_vend), .s_follow(s_follow)
  );

  rtg_counter #(.HW(HW), .VW(VW)) u_counter (
    .clk(clk), .rst_n(rst_n), .en(en), .hp(s_hp), .vp(s_vp),
    .h(h_cnt), .v(v_cnt), .lin(lin), .frame_end(frame_end)
  );

  rtg_decode #(.HW(HW), .VW(VW)) u_decode (
    .en(en), .h(h_cnt), .v(v_cnt), .lin(lin),
    .s_hsw(s_hsw), .s_vsw(s_vsw), .s_hstart(s_hstart), .s_hend(s_hend),
    .s_dend(s_dend), .s_vstart(s_vstart), .s_vend(s_vend), .s_follow(s_follow),
    .hsync(hsync), .vsync(vsync), .de(de), .dv(dv)
  );

endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          dv,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt
);

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && h_cnt != '0) |-> (h_cnt == $past(h_cnt) + HW'(1))); // R1

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && h_cnt != '0) |-> (v_cnt == $past(v_cnt))); // R1

  AST_DE_CLEAR_OF_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync); // R3

  AST_DE_CLEAR_OF_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !vsync); // R4

  AST_DV_CLEAR_OF_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    dv |-> !hsync); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !(hsync || vsync || de || dv)); // R10

endmodule

bind raster_timing_gen rtg_checker #(.HW(HW), .VW(VW)) u_chk (.*);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  localparam int HW = 12;
  localparam int VW = 12;
  localparam int BW = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, en;
  logic [HW-1:0] c_hsw, c_hbp, c_hact, c_hfp, c_skew;
  logic [VW-1:0] c_vsw, c_vbp, c_vact, c_vfp;
  logic c_comp, c_wide, c_dp;
  logic [BW-1:0] c_bytes;
  logic hsync, vsync, de, dv;
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;

  raster_timing_gen #(.HW(HW), .VW(VW), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en),
    .cfg_hsync_w(c_hsw), .cfg_hbp(c_hbp), .cfg_hact(c_hact), .cfg_hfp(c_hfp),
    .cfg_vsync_w(c_vsw), .cfg_vbp(c_vbp), .cfg_vact(c_vact), .cfg_vfp(c_vfp),
    .cfg_hskew(c_skew), .cfg_comp_en(c_comp), .cfg_comp_bytes(c_bytes),
    .cfg_wide_en(c_wide), .cfg_dp_mode(c_dp),
    .hsync(hsync), .vsync(vsync), .de(de), .dv(dv), .h_cnt(h_cnt), .v_cnt(v_cnt)
  );

  int n_run = 0, n_fail = 0;
  bit active = 0, done = 0;
  string scen = "idle";

  // behavioural model state: position and captured configuration
  int mh, mv;
  int s_hsw, s_hbp, s_hact, s_hfp, s_vsw, s_vbp, s_vact, s_vfp, s_skew, s_bytes;
  int s_comp, s_wide, s_dp;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s] h=%0d v=%0d: actual %0d expected %0d", req, scen, mh, mv, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mh = 0; mv = 0;
      s_hsw = 0; s_hbp = 0; s_hact = 0; s_hfp = 0; s_vsw = 0; s_vbp = 0;
      s_vact = 0; s_vfp = 0; s_skew = 0; s_bytes = 0; s_comp = 0; s_wide = 0; s_dp = 0;
    end else begin
      int hp, vp;
      bit wrap;
      hp = s_hsw + s_hbp + s_hact + s_hfp;
      vp = s_vsw + s_vbp + s_vact + s_vfp;
      wrap = en && (mh == hp - 1) && (mv == vp - 1);
      if (!en) begin mh = 0; mv = 0; end
      else if (mh == hp - 1) begin mh = 0; mv = (mv == vp - 1) ? 0 : mv + 1; end
      else mh = mh + 1;
      if (!en || wrap) begin   // R11 capture points
        s_hsw = c_hsw; s_hbp = c_hbp; s_hact = c_hact; s_hfp = c_hfp;
        s_vsw = c_vsw; s_vbp = c_vbp; s_vact = c_vact; s_vfp = c_vfp;
        s_skew = c_skew; s_bytes = c_bytes; s_comp = c_comp; s_wide = c_wide; s_dp = c_dp;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && active && !done) begin
      int hp, vp, lin, vs, ve, hs, he, dw, e_de, e_dv, e_hs, e_vs;
      bit inv, inh, ind;
      string tde, tdv;
      hp  = s_hsw + s_hbp + s_hact + s_hfp;
      vp  = s_vsw + s_vbp + s_vact + s_vfp;
      lin = mv * hp + mh;
      vs  = (s_vsw + s_vbp) * hp + s_skew;              // R4
      ve  = (vp - s_vfp) * hp + s_skew - 1;
      if (s_dp != 0) begin vs = vs + s_hsw + s_hbp; ve = ve - s_hfp; end // R5
      hs  = s_hsw + s_hbp;                              // R3
      he  = hp - s_hfp - 1;
      if (s_comp != 0) dw = ((s_bytes + 2) / 3) >> s_wide;             // R6
      else if (s_wide != 0 && s_dp == 0) dw = s_hact >> 1;             // R7
      else dw = s_hact;
      inv = (lin >= vs) && (lin <= ve);
      inh = (mh >= hs) && (mh <= he);
      ind = (s_comp != 0 && s_wide == 0) ? inh : ((mh >= hs) && (mh <= hs + dw - 1));
      e_hs = (en && mh < s_hsw) ? 1 : 0;
      e_vs = (en && mv < s_vsw) ? 1 : 0;
      e_de = (en && inv && inh) ? 1 : 0;
      e_dv = (en && inv && ind) ? 1 : 0;
      tde = (s_dp != 0) ? "R3 R4 R5 de" : "R3 R4 de";
      if (s_comp != 0 && s_wide == 0) tdv = "R9 dv";
      else if (s_comp != 0) tdv = "R6 R8 dv";
      else tdv = "R7 R8 dv";
      if (!en) begin tde = "R10 de"; tdv = "R10 dv"; end
      chk("R1 h_cnt", int'(h_cnt), mh);
      chk("R1 v_cnt", int'(v_cnt), mv);
      chk(en ? "R2 hsync" : "R10 hsync", int'(hsync), e_hs);
      chk(en ? "R2 vsync" : "R10 vsync", int'(vsync), e_vs);
      chk(tde, int'(de), e_de);
      chk(tdv, int'(dv), e_dv);
    end
  end

  task automatic set_cfg(int hsw, int hbp, int hact, int hfp, int vsw, int vbp, int vact,
                         int vfp, int skew, int comp, int bytes, int wide, int dp);
    c_hsw = HW'(hsw); c_hbp = HW'(hbp); c_hact = HW'(hact); c_hfp = HW'(hfp);
    c_vsw = VW'(vsw); c_vbp = VW'(vbp); c_vact = VW'(vact); c_vfp = VW'(vfp);
    c_skew = HW'(skew); c_comp = comp[0]; c_bytes = BW'(bytes);
    c_wide = wide[0]; c_dp = dp[0];
  endtask

  task automatic run_mode(int hsw, int hbp, int hact, int hfp, int vsw, int vbp, int vact,
                          int vfp, int skew, int comp, int bytes, int wide, int dp, int frames);
    @(negedge clk);
    en = 1'b0;
    set_cfg(hsw, hbp, hact, hfp, vsw, vbp, vact, vfp, skew, comp, bytes, wide, dp);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (frames * (hsw + hbp + hact + hfp) * (vsw + vbp + vact + vfp) + 4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    en = 1'b0;
    set_cfg(2, 3, 8, 2, 1, 2, 3, 1, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    scen = "reset";
    chk("R10 reset hsync", int'(hsync), 0);
    chk("R10 reset vsync", int'(vsync), 0);
    chk("R10 reset de", int'(de), 0);
    chk("R10 reset dv", int'(dv), 0);
    chk("R10 reset h_cnt", int'(h_cnt), 0);
    chk("R10 reset v_cnt", int'(v_cnt), 0);
    rst_n = 1'b1;
    active = 1;

    // every flag combination, two byte counts (odd ceil and odd halving)
    foreach (scen_bytes[i]) begin
      for (int m = 0; m < 8; m++) begin
        scen = $sformatf("flags comp=%0d wide=%0d dp=%0d bytes=%0d", m & 1, (m >> 1) & 1,
                         (m >> 2) & 1, scen_bytes[i]);
        run_mode(2, 3, 8, 2, 1, 2, 3, 1, 0, m & 1, scen_bytes[i], (m >> 1) & 1, (m >> 2) & 1, 2);
      end
    end

    // skew cutting into the first active line, plain and edge-aligned (R4 R5)
    scen = "skew";
    run_mode(3, 4, 10, 3, 2, 1, 4, 2, 12, 0, 0, 0, 0, 2);
    scen = "skew dp";
    run_mode(3, 4, 10, 3, 2, 1, 4, 2, 12, 0, 0, 1, 1, 2);

    // R11: change configuration in mid-frame; must only apply from the next frame
    scen = "R11 midframe";
    @(negedge clk);
    en = 1'b0;
    set_cfg(2, 3, 8, 2, 1, 2, 3, 1, 0, 1, 20, 1, 0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (40) @(negedge clk);
    set_cfg(1, 2, 6, 5, 2, 1, 2, 2, 0, 0, 0, 1, 0);
    repeat (3 * 105) @(negedge clk);

    // R10: drop enable mid-frame and restart from origin
    scen = "R10 restart";
    repeat (17) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    repeat (150) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  int scen_bytes[2] = '{20, 13};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule